// File: doc/BRIEF.md
# Carry-Skip Adder

This block adds two unsigned binary words and a carry input in a single combinational pass. It returns the word-wide sum and the final carry. The word is cut into equal groups of bits. Inside each group the carry moves from one bit position to the next.

Each group also has a bypass. When every bit of a group has differing operand bits, whatever carry enters the group must also leave it. In that case a multiplexer hands the group's incoming carry straight to the next group, instead of waiting for the internal chain.

The word width and the group width are both parameters. The group width must divide the word width, and any other choice stops elaboration with an error.

Top module: `carry_skip_adder`

## Requirements
- R1: For every a_i, b_i and c_i, the value {c_o, sum_o} equals the unsigned N+1-bit sum a_i + b_i + c_i.
- R2: When every bit of a group propagates (a_i bit XOR b_i bit is 1 across the whole group), the group's carry-out equals its carry-in. Bits below the group then pass the carry through it unchanged.
- R3: When a group does not skip, its carry-out equals the carry produced by its internal bit-to-bit chain.
- R4: When both operand bits are 0 in every position of a group, that group's carry-out is 0, whatever its carry-in.
- R5: When both operand bits are 1 in every position of a group, that group's carry-out is 1, whatever its carry-in.
- R6: With all operand bits differing across the whole word and c_i = 1, the carry passes every group: sum_o is all zeros and c_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| c_o | output | 1 | Carry out of the top group |

## Verification
The bypass multiplexer can pick the wrong carry, or a group's skip condition can be formed wrongly. Either fault shows at once as a wrong sum in the next group up, or as a wrong c_o. There is no state, so the error appears in the same evaluation as the operands that trigger it. A small configuration is swept over every operand pair and both carry-in values. Directed words then force groups to skip, kill and generate a carry, so that each bypass path is observed through the sum bits above it.

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
  parameter int N = 16,
  parameter int M = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         c_i,
  output logic [N-1:0] sum_o,
  output logic         c_o
);
  localparam int GROUPS = N / M;

  if (M < 1 || (N % M) != 0) begin : g_bad_cfg
    $error("carry_skip_adder: group width must divide word width");
  end

  logic [GROUPS:0] gc;
  assign gc[0] = c_i;
  assign c_o   = gc[GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [M-1:0] ga, gb, prop, gen;
    logic [M:0]   chain;
    logic         skip;

    assign ga       = a_i[g*M +: M];
    assign gb       = b_i[g*M +: M];
    assign prop     = ga ^ gb;
    assign gen      = ga & gb;
    assign skip     = &prop;
    assign chain[0] = gc[g];

    for (genvar k = 0; k < M; k++) begin : g_bit
      assign chain[k+1]       = gen[k] | (prop[k] & chain[k]);
      assign sum_o[g*M + k]   = prop[k] ^ chain[k];
    end

    assign gc[g+1] = skip ? gc[g] : chain[M];

    always_comb begin
      // R2
      if (skip) begin
        skip_pass_chk: assert (chain[M] == gc[g]);
      end
      // R3
      if (!skip) begin
        ripple_sel_chk: assert (gc[g+1] == chain[M]);
      end
      // R4
      if ((ga | gb) == '0) begin
        kill_grp_chk: assert (gc[g+1] == 1'b0);
      end
      // R5
      if ((ga & gb) == {M{1'b1}}) begin
        gen_grp_chk: assert (gc[g+1] == 1'b1);
      end
    end
  end

  always_comb begin
    // R1
    sum_ref_chk: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, c_i}));
  end
endmodule

// File: tb/carry_skip_adder_tb.sv
module carry_skip_adder_tb;
  localparam int N = 8;
  localparam int M = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] a, b, s;
  logic cin, cout;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  carry_skip_adder #(.N(N), .M(M)) u_dut (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(s), .c_o(cout)
  );

  task automatic check(input string req, input logic [N:0] exp);
    checks++;
    if ({cout, s} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, {cout, s}, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic c, input string req);
    a = x; b = y; cin = c;
    #1;
    check(req, {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: zero operands
    check("R1 zero", '0);
    // R6: full-word skip, 0x55 ^ 0xAA all propagate
    apply(8'h55, 8'hAA, 1'b1, "R6");
    check("R6 explicit", {1'b1, 8'h00});
    // R2: low group skips (bits 1:0 = 01/10), carry passes into bit 2
    apply(8'h01, 8'h02, 1'b1, "R2");
    check("R2 explicit", 9'h004);
    apply(8'h01, 8'h02, 1'b0, "R2 no carry");
    // R3: group rippling without skip, carry generated at bit 0
    apply(8'h01, 8'h01, 1'b0, "R3");
    apply(8'h03, 8'h01, 1'b0, "R3 ripple");
    // R4: low group kills incoming carry
    apply(8'hFC, 8'h00, 1'b1, "R4");
    check("R4 explicit", {1'b0, 8'hFD});
    // R5: low group generates with cin 0
    apply(8'h03, 8'h03, 1'b0, "R5");
    apply(8'hFF, 8'hFF, 1'b1, "R5 top");
    check("R5 explicit", 9'h1FF);
    // R1: exhaustive sweep
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          apply(x[N-1:0], y[N-1:0], c[0], "R1 sweep");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule